// File: doc/BRIEF.md
# Per-Tone Complex One-Tap Frequency-Domain Equalizer

This block sits after the FFT of a multitone receiver. It corrects the gain and phase of each tone separately. Tones arrive one at a time, each carrying a tone index, a complex sample and a complex reference (training or decided) symbol. For every tone inside the active band, the block looks up that tone's complex coefficient in a register file and multiplies it with the sample. It emits the product together with the error between the reference and that product. It then adapts the coefficient with a least-mean-square step that uses the conjugate of the sample and a power-of-two gain, so the gain needs only a shift.

Samples and outputs are signed 16-bit values with 14 fractional bits. Coefficients are signed 16-bit values with 13 fractional bits, so 1.0 is 8192. A tone is taken on a cycle where `in_valid` and `in_ready` are both high. The read, the multiply and the write-back finish before the next tone is taken. Two inputs control adaptation per tone: a freeze flag and a step selector. A tone outside the band passes straight through and never touches the register file.

Top module: `tone_feq`

## Requirements
- R1: After reset every coefficient equals 1+0j (8192, 0), so an in-band tone comes out equal to its input.
- R2: For an in-band tone, out = w·x computed from four real products. Each part is rounded by adding 2^12 and then shifting arithmetically right by 13.
- R3: A rounded output part above 32767 becomes 32767, and one below -32768 becomes -32768.
- R4: err_re/err_im are 17-bit signed values equal to ref − out, taken part by part.
- R5: Unless frozen, an in-band tone's coefficient becomes w + ((e·conj(x)) >>> (15+k)), with each part saturated to 16 bits. The shift is arithmetic, so it truncates toward minus infinity.
- R6: step_sel picks k: 0 gives k=1, 1 gives k=3, 2 gives k=5, 3 gives k=7.
- R7: With freeze high, the output and error are produced as usual but the coefficient stays unchanged.
- R8: The band is tone indices 7 to 256 inclusive. For any other index, out equals the input, err equals ref minus input, and no coefficient is read or written.
- R9: After an accept edge, out_valid is high for exactly one cycle, following the second rising edge. in_ready is low from the accept edge until the third rising edge.
- R10: A one-cycle init pulse while idle resets every coefficient to 1+0j.
- R11: out_tone carries the index of the tone whose result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init | input | 1 | Resets all coefficients to 1+0j |
| in_valid | input | 1 | Tone present on the inputs |
| in_ready | output | 1 | Block can take a tone |
| in_tone | input | 9 | Tone index |
| in_re | input | 16 | Sample, real part |
| in_im | input | 16 | Sample, imaginary part |
| ref_re | input | 16 | Reference symbol, real part |
| ref_im | input | 16 | Reference symbol, imaginary part |
| step_sel | input | 2 | Adaptation step select |
| freeze | input | 1 | Suppresses coefficient write-back for this tone |
| out_valid | output | 1 | Result present |
| out_tone | output | 9 | Index of the presented tone |
| out_re | output | 16 | Equalized value, real part |
| out_im | output | 16 | Equalized value, imaginary part |
| err_re | output | 17 | Error, real part |
| err_im | output | 17 | Error, imaginary part |

## Verification
The result of a tone is due in the cycle that follows the second rising edge after its accept edge. The coefficient written back takes effect at the third edge, which is when in_ready returns. The bench drives inputs on falling edges. It confirms that out_valid is still low one falling edge after the accept and high at the next one, and it reads the result there. The effect of an adaptation step is checked only on a later tone, sent with freeze set and a sample of 1.0, whose output reads out twice the stored coefficient.

// File: rtl/feq_pkg.sv
package feq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_UPD  = 2'd2
  } feq_state_e;
endpackage

// File: rtl/feq_cmul.sv
module feq_cmul #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CFRAC = 13
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [CW-1:0] w_re,
  input  logic signed [CW-1:0] w_im,
  output logic signed [DW-1:0] p_re,
  output logic signed [DW-1:0] p_im
);
  localparam int MW = DW + CW;
  localparam int PW = MW + 1;
  localparam logic signed [PW-1:0] RND = {{(PW-1){1'b0}}, 1'b1} << (CFRAC - 1);

  logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [PW-1:0] s_re, s_im, q_re, q_im;

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (!v[PW-1] && (|v[PW-2:DW-1]))      clip = {1'b0, {(DW-1){1'b1}}};
    else if (v[PW-1] && !(&v[PW-2:DW-1])) clip = {1'b1, {(DW-1){1'b0}}};
    else                                  clip = v[DW-1:0];
  endfunction

  always_comb begin
    m_rr = a_re * w_re;
    m_ii = a_im * w_im;
    m_ri = a_re * w_im;
    m_ir = a_im * w_re;
    s_re = {m_rr[MW-1], m_rr} - {m_ii[MW-1], m_ii};
    s_im = {m_ri[MW-1], m_ri} + {m_ir[MW-1], m_ir};
    q_re = (s_re + RND) >>> CFRAC;
    q_im = (s_im + RND) >>> CFRAC;
    p_re = clip(q_re);
    p_im = clip(q_im);
  end
endmodule

// File: rtl/feq_lms_upd.sv
module feq_lms_upd #(
  parameter int DW    = 16,
  parameter int DFRAC = 14,
  parameter int CW    = 16,
  parameter int CFRAC = 13
) (
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic signed [DW:0]   e_re,
  input  logic signed [DW:0]   e_im,
  input  logic signed [CW-1:0] w_re,
  input  logic signed [CW-1:0] w_im,
  input  logic [1:0]           step_sel,
  output logic signed [CW-1:0] wn_re,
  output logic signed [CW-1:0] wn_im
);
  localparam int EW   = DW + 1;
  localparam int MW   = EW + DW;
  localparam int PW   = MW + 1;
  localparam int BASE = 2 * DFRAC - CFRAC;

  logic signed [MW-1:0] m_rr, m_ii, m_ir, m_ri;
  logic signed [PW-1:0] g_re, g_im, d_re, d_im, s_re, s_im;
  logic [5:0]           sh;

  function automatic logic signed [CW-1:0] clip(input logic signed [PW-1:0] v);
    if (!v[PW-1] && (|v[PW-2:CW-1]))      clip = {1'b0, {(CW-1){1'b1}}};
    else if (v[PW-1] && !(&v[PW-2:CW-1])) clip = {1'b1, {(CW-1){1'b0}}};
    else                                  clip = v[CW-1:0];
  endfunction

  always_comb begin
    // e * conj(x): (er + j ei)(xr - j xi)
    m_rr = e_re * x_re;
    m_ii = e_im * x_im;
    m_ir = e_im * x_re;
    m_ri = e_re * x_im;
    g_re = {m_rr[MW-1], m_rr} + {m_ii[MW-1], m_ii};
    g_im = {m_ir[MW-1], m_ir} - {m_ri[MW-1], m_ri};
    sh   = 6'(BASE + 2 * int'(step_sel) + 1);
    d_re = g_re >>> sh;
    d_im = g_im >>> sh;
    s_re = {{(PW-CW){w_re[CW-1]}}, w_re} + d_re;
    s_im = {{(PW-CW){w_im[CW-1]}}, w_im} + d_im;
    wn_re = clip(s_re);
    wn_im = clip(s_im);
  end
endmodule

// File: rtl/feq_coef_rf.sv
module feq_coef_rf #(
  parameter int NENT  = 250,
  parameter int CW    = 16,
  parameter int CFRAC = 13,
  parameter int AW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [CW-1:0] wd_re,
  input  logic signed [CW-1:0] wd_im,
  input  logic [AW-1:0]        raddr,
  output logic signed [CW-1:0] rd_re,
  output logic signed [CW-1:0] rd_im
);
  localparam logic signed [CW-1:0] UNITY = {{(CW-1){1'b0}}, 1'b1} << CFRAC;

  logic signed [CW-1:0] m_re [NENT];
  logic signed [CW-1:0] m_im [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic hit;
    assign hit = we && (int'(waddr) == e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_re[e] <= UNITY;
        m_im[e] <= '0;
      end else if (init) begin
        m_re[e] <= UNITY;
        m_im[e] <= '0;
      end else if (hit) begin
        m_re[e] <= wd_re;
        m_im[e] <= wd_im;
      end
    end
  end

  always_comb begin
    if (int'(raddr) < NENT) begin
      rd_re = m_re[raddr];
      rd_im = m_im[raddr];
    end else begin
      rd_re = UNITY;
      rd_im = '0;
    end
  end
endmodule

// File: rtl/tone_feq.sv
module tone_feq #(
  parameter int DW      = 16,
  parameter int DFRAC   = 14,
  parameter int CW      = 16,
  parameter int CFRAC   = 13,
  parameter int TW      = 9,
  parameter int TONE_LO = 7,
  parameter int TONE_HI = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [TW-1:0]        in_tone,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic signed [DW-1:0] ref_re,
  input  logic signed [DW-1:0] ref_im,
  input  logic [1:0]           step_sel,
  input  logic                 freeze,
  output logic                 out_valid,
  output logic [TW-1:0]        out_tone,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic signed [DW:0]   err_re,
  output logic signed [DW:0]   err_im
);
  import feq_pkg::*;

  localparam int NENT = TONE_HI - TONE_LO + 1;
  localparam int AW   = $clog2(NENT);
  localparam logic signed [CW-1:0] UNITY = {{(CW-1){1'b0}}, 1'b1} << CFRAC;

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  feq_state_e st_q, st_d;
  logic                 acc, act_d;
  logic [AW-1:0]        idx_d;
  logic [TW-1:0]        tone_q;
  logic signed [DW-1:0] x_re_q, x_im_q, r_re_q, r_im_q;
  logic [1:0]           sel_q;
  logic                 frz_q, act_q;
  logic [AW-1:0]        idx_q;
  logic                 ov_q;
  logic signed [DW-1:0] y_re_q, y_im_q, p_re, p_im;
  logic signed [DW:0]   e_re_q, e_im_q, e_re_d, e_im_d;
  logic signed [CW-1:0] rd_re, rd_im, w_re, w_im, wn_re, wn_im;
  logic                 we;

  assign in_ready = (st_q == ST_IDLE) && rst_i_n;
  assign acc      = in_valid && in_ready;

  always_comb begin
    act_d = (int'(in_tone) >= TONE_LO) && (int'(in_tone) <= TONE_HI);
    idx_d = AW'(int'(in_tone) - TONE_LO);
    unique case (st_q)
      ST_IDLE: st_d = acc ? ST_MUL : ST_IDLE;
      ST_MUL:  st_d = ST_UPD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  // capture of the accepted tone
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tone_q <= '0; x_re_q <= '0; x_im_q <= '0; r_re_q <= '0; r_im_q <= '0;
      sel_q  <= '0; frz_q  <= 1'b1; act_q <= 1'b0; idx_q <= '0;
    end else if (acc) begin
      tone_q <= in_tone; x_re_q <= in_re; x_im_q <= in_im;
      r_re_q <= ref_re;  r_im_q <= ref_im;
      sel_q  <= step_sel; frz_q <= freeze; act_q <= act_d;
      idx_q  <= act_d ? idx_d : '0;
    end
  end

  feq_coef_rf #(.NENT(NENT), .CW(CW), .CFRAC(CFRAC), .AW(AW)) rf_i (
    .clk(clk), .rst_n(rst_i_n), .init(init), .we(we), .waddr(idx_q),
    .wd_re(wn_re), .wd_im(wn_im), .raddr(idx_q), .rd_re(rd_re), .rd_im(rd_im)
  );

  // out-of-band tones see unity instead of a stored coefficient
  assign w_re = act_q ? rd_re : UNITY;
  assign w_im = act_q ? rd_im : '0;

  feq_cmul #(.DW(DW), .CW(CW), .CFRAC(CFRAC)) mul_i (
    .a_re(x_re_q), .a_im(x_im_q), .w_re(w_re), .w_im(w_im),
    .p_re(p_re), .p_im(p_im)
  );

  assign e_re_d = {r_re_q[DW-1], r_re_q} - {p_re[DW-1], p_re};
  assign e_im_d = {r_im_q[DW-1], r_im_q} - {p_im[DW-1], p_im};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ov_q <= 1'b0;
      y_re_q <= '0; y_im_q <= '0; e_re_q <= '0; e_im_q <= '0;
    end else begin
      ov_q <= (st_q == ST_MUL);
      if (st_q == ST_MUL) begin
        y_re_q <= p_re;   y_im_q <= p_im;
        e_re_q <= e_re_d; e_im_q <= e_im_d;
      end
    end
  end

  feq_lms_upd #(.DW(DW), .DFRAC(DFRAC), .CW(CW), .CFRAC(CFRAC)) upd_i (
    .x_re(x_re_q), .x_im(x_im_q), .e_re(e_re_q), .e_im(e_im_q),
    .w_re(rd_re), .w_im(rd_im), .step_sel(sel_q), .wn_re(wn_re), .wn_im(wn_im)
  );

  assign we = (st_q == ST_UPD) && act_q && !frz_q;

  assign out_valid = ov_q;
  assign out_tone  = tone_q;
  assign out_re    = y_re_q;
  assign out_im    = y_im_q;
  assign err_re    = e_re_q;
  assign err_im    = e_im_q;
endmodule

// File: rtl/tone_feq_chk.sv
module tone_feq_chk #(
  parameter int DW      = 16,
  parameter int TW      = 9,
  parameter int TONE_LO = 7,
  parameter int TONE_HI = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [TW-1:0]        in_tone,
  input logic signed [DW-1:0] in_re,
  input logic signed [DW-1:0] in_im,
  input logic signed [DW-1:0] ref_re,
  input logic signed [DW-1:0] ref_im,
  input logic                 out_valid,
  input logic [TW-1:0]        out_tone,
  input logic signed [DW-1:0] out_re,
  input logic signed [DW-1:0] out_im,
  input logic signed [DW:0]   err_re,
  input logic signed [DW:0]   err_im
);
  logic oob;
  assign oob = (int'(out_tone) < TONE_LO) || (int'(out_tone) > TONE_HI);

  p_handshake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid) ##1 (!in_ready && out_valid) ##1 !out_valid);

  p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_tone_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_tone == $past(in_tone, 2));

  p_err_re_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> err_re == ((DW+1)'($past(ref_re, 2)) - (DW+1)'(out_re)));

  p_err_im_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> err_im == ((DW+1)'($past(ref_im, 2)) - (DW+1)'(out_im)));

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && oob) |-> (out_re == $past(in_re, 2) && out_im == $past(in_im, 2)));
endmodule

bind tone_feq tone_feq_chk #(.DW(DW), .TW(TW), .TONE_LO(TONE_LO), .TONE_HI(TONE_HI)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_tone(in_tone),
  .in_re(in_re), .in_im(in_im), .ref_re(ref_re), .ref_im(ref_im),
  .out_valid(out_valid), .out_tone(out_tone), .out_re(out_re), .out_im(out_im),
  .err_re(err_re), .err_im(err_im)
);

// File: tb/tone_feq_tb_top.sv
module tone_feq_tb_top;
  localparam int CLK_PER = 10;
  localparam int NV = 22;
  // tone, xr, xi, rr, ri, sel, frz, exp yr, yi, er, ei
  localparam int VEC [NV][11] = '{
    '{ 10,   4096,      0,   8192,   0, 0, 0,   4096,      0,   4096,     0}, // R1 R5 train tone 10
    '{ 10,  16384,      0,      0,   0, 0, 1,  16896,      0, -16896,     0}, // R5 R7 w=8448
    '{ 10,  16384,      0,      0,   0, 0, 1,  16896,      0, -16896,     0}, // R7 still 8448
    '{ 11,      0,   8192,      0,   0, 1, 0,      0,   8192,      0, -8192}, // R6 step 2^-3
    '{ 11,  16384,      0,  15872, 100, 0, 1,  15872,      0,      0,   100}, // R6 R4 w=7936
    '{ 12,   8192,      0,      0,8192, 0, 0,   8192,      0,  -8192,  8192}, // R5 complex update
    '{ 12,   4096,   2048,      0,   0, 0, 1,   3328,   2304,  -3328, -2304}, // R2 w=(7168,1024)
    '{ 12,      1,      0,      0,   0, 0, 1,      1,      0,     -1,     0}, // R2 round up
    '{ 12,     -1,      0,      0,   0, 0, 1,     -1,      0,      1,     0}, // R2 round negative
    '{ 13,  16384,      0, -16384,   0, 3, 0,  16384,      0, -32768,     0}, // R6 step 2^-7
    '{ 13,  16384,      0,      0,   0, 0, 1,  16128,      0, -16128,     0}, // R6 w=8064
    '{ 14,  16384,      0, -16384,   0, 2, 0,  16384,      0, -32768,     0}, // R6 step 2^-5
    '{ 14,  16384,      0,      0,   0, 0, 1,  15360,      0, -15360,     0}, // R6 w=7680
    '{  5,   1234,   -567,      0,   0, 0, 0,   1234,   -567,  -1234,   567}, // R8 below band
    '{257,   1234,   -567,      0,   0, 0, 0,   1234,   -567,  -1234,   567}, // R8 above band
    '{  6,   1234,   -567,      0,   0, 0, 0,   1234,   -567,  -1234,   567}, // R8 just below
    '{  7,   4096,      0,   8192,   0, 0, 0,   4096,      0,   4096,     0}, // R8 lowest in band
    '{  7,  16384,      0,      0,   0, 0, 1,  16896,      0, -16896,     0}, // R8 adapted
    '{256,   4096,      0,   8192,   0, 0, 0,   4096,      0,   4096,     0}, // R8 highest in band
    '{256,  16384,      0,      0,   0, 0, 1,  16896,      0, -16896,     0}, // R8 adapted
    '{ 10,  32767, -32768,      0,   0, 0, 1,  32767, -32768, -32767, 32768}, // R3 saturation
    '{ 12,  16384,      0,      0,   0, 0, 1,  14336,   2048, -14336, -2048}  // R8 tone 12 untouched
  };

  logic clk, rst_n, init, in_valid, in_ready, freeze, out_valid;
  logic [8:0] in_tone, out_tone;
  logic signed [15:0] in_re, in_im, ref_re, ref_im, out_re, out_im;
  logic signed [16:0] err_re, err_im;
  logic [1:0] step_sel;
  int n_chk, n_fail;
  bit done;

  tone_feq dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid), .in_ready(in_ready),
    .in_tone(in_tone), .in_re(in_re), .in_im(in_im), .ref_re(ref_re), .ref_im(ref_im),
    .step_sel(step_sel), .freeze(freeze), .out_valid(out_valid), .out_tone(out_tone),
    .out_re(out_re), .out_im(out_im), .err_re(err_re), .err_im(err_im)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives one tone at a falling edge and returns at the falling edge where the result is due
  task automatic send(input int tone, input int xr, input int xi, input int rr, input int ri,
                      input int sel, input int frz);
    int guard = 0;
    while (!in_ready && guard < 20) begin @(negedge clk); guard++; end
    in_valid = 1'b1; in_tone = 9'(tone); in_re = 16'(xr); in_im = 16'(xi);
    ref_re = 16'(rr); ref_im = 16'(ri); step_sel = 2'(sel); freeze = frz[0];
    @(negedge clk);
    in_valid = 1'b0;
    check(!out_valid && !in_ready, "R9 busy after accept", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid === 1'b1, "R9 result due", int'(out_valid), 1);
    check(int'(out_tone) == tone, "R11 tone tag", int'(out_tone), tone);
  endtask

  task automatic expect_out(input string tag, input int yr, input int yi, input int er, input int ei);
    check(int'(out_re) == yr, tag, int'(out_re), yr);
    check(int'(out_im) == yi, tag, int'(out_im), yi);
    check(int'(err_re) == er, tag, int'(err_re), er);
    check(int'(err_im) == ei, tag, int'(err_im), ei);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid, "R9 quiet in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R9 ready after reset", int'(in_ready), 1);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    init = 1'b0; in_valid = 1'b0; in_tone = '0; in_re = '0; in_im = '0;
    ref_re = '0; ref_im = '0; step_sel = '0; freeze = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);
      expect_out($sformatf("R2/R4 vector %0d", i), VEC[i][7], VEC[i][8], VEC[i][9], VEC[i][10]);
      @(negedge clk);
      check(!out_valid, "R9 single pulse", int'(out_valid), 0);
    end

    // R10: init pulse restores unity on adapted tones
    init = 1'b1; @(negedge clk); init = 1'b0;
    send(10, 16384, 0, 0, 0, 0, 1);
    expect_out("R10 tone 10 after init", 16384, 0, -16384, 0);
    send(12, 16384, 0, 0, 0, 0, 1);
    expect_out("R10 tone 12 after init", 16384, 0, -16384, 0);

    // R1: reset restores unity
    send(14, 16384, 0, -16384, 0, 2, 0);
    send(14, 16384, 0, 0, 0, 0, 1);
    expect_out("R5 retrain before reset", 15360, 0, -15360, 0);
    @(negedge clk);
    do_reset();
    send(14, 16384, 0, 0, 0, 0, 1);
    expect_out("R1 unity after reset", 16384, 0, -16384, 0);

    // R7 R3: frozen saturating tone keeps coefficient
    send(20, -32768, -32768, 0, 0, 3, 1);
    expect_out("R3 unity full scale", -32768, -32768, 32768, 32768);
    send(20, 16384, 0, 0, 0, 0, 1);
    expect_out("R7 frozen unchanged", 16384, 0, -16384, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule